// File: doc/BRIEF.md
# Triple-Copy Majority Voter with Fault Reporting

This block resolves the outputs of three identical datapath copies that are fed the same inputs. Each copy presents a data word and a valid flag. Three independent bitwise majority voters each see all three copies. A final majority voter then combines the three voter results. The voted data and voted valid leave the block through a register stage, so the latency is one clock cycle.

Masking a fault on its own hides it, and a later second fault would then defeat the vote. To prevent this, the block compares every copy with the final voted word, where the word is the valid flag together with the data. It reports which copies disagree. A single mismatch flag is meant to start an external scrubbing or repair engine. A separate flag is raised when two or more copies disagree at once, because the vote can no longer be trusted in that case. All report outputs are registered in the same cycle as the voted data.

Top module: `tmr_vote_top`

## Requirements
- R1: Each bit of `vote_data` equals the majority of the three copies' data bits at that position, sampled at the previous rising clock edge (one-cycle latency).
- R2: When exactly one copy differs from the other two, `vote_data` and `vote_valid` equal the value shared by the two agreeing copies.
- R3: `vote_valid` is the majority of the three copies' valid flags, with the same one-cycle latency as the data.
- R4: `fault_mask` has one bit per copy: bit 0 for copy 0, bit 1 for copy 1 and bit 2 for copy 2. A bit is 1 when that copy's {valid, data} pair differed from the voted pair in the previous cycle.
- R5: `mismatch` is 1 exactly when, in the previous cycle, at least one copy's {valid, data} differed from the voted pair. A difference in the valid flag alone also counts.
- R6: `uncorrectable` is 1 exactly when two or three copies differed from the voted pair in the previous cycle.
- R7: While `rst` is high at a rising edge, all outputs become 0 after that edge.
- R8: When all three copies are equal, the next cycle shows that common value on `vote_data`/`vote_valid`, with `fault_mask` at 3'b000 and `mismatch` and `uncorrectable` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| copy0_data | input | WIDTH | Data from copy 0 |
| copy0_valid | input | 1 | Valid from copy 0 |
| copy1_data | input | WIDTH | Data from copy 1 |
| copy1_valid | input | 1 | Valid from copy 1 |
| copy2_data | input | WIDTH | Data from copy 2 |
| copy2_valid | input | 1 | Valid from copy 2 |
| vote_data | output | WIDTH | Registered voted data |
| vote_valid | output | 1 | Registered voted valid |
| fault_mask | output | 3 | Registered per-copy disagreement, bit k for copy k |
| mismatch | output | 1 | Registered: any copy disagreed |
| uncorrectable | output | 1 | Registered: two or more copies disagreed |

## Verification
The assertions assume that the copy inputs are driven to known values and stay steady around each rising edge. They also assume that reset is asserted before the first check that looks one cycle back. The stimulus changes the inputs only on falling edges and holds reset for several cycles at start-up and again in the middle of the run. Apart from the reset periods, the stimulus keeps valid and data varied freely, including valid-only disagreements and patterns in which two or three copies are each wrong in different bits.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
  localparam int NUM_COPIES = 3;
  typedef logic [NUM_COPIES-1:0] copy_mask_t;
endpackage

// File: rtl/tmr_maj3.sv
module tmr_maj3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  // bitwise two-of-three
  assign y = (a & b) | (b & c) | (a & c);
endmodule

// File: rtl/tmr_voter_bank.sv
module tmr_voter_bank #(
  parameter int W = 8
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  output logic [W-1:0] voted
);
  import tmr_vote_pkg::*;

  logic [W-1:0] stage [NUM_COPIES];

  // three independent first-level voters, each seeing all copies
  for (genvar i = 0; i < NUM_COPIES; i++) begin : g_voter
    tmr_maj3 #(.W(W)) u_maj (
      .a(in0),
      .b(in1),
      .c(in2),
      .y(stage[i])
    );
  end

  // final voter over the three voter results
  tmr_maj3 #(.W(W)) u_final (
    .a(stage[0]),
    .b(stage[1]),
    .c(stage[2]),
    .y(voted)
  );
endmodule

// File: rtl/tmr_copy_compare.sv
module tmr_copy_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0]             c0,
  input  logic [W-1:0]             c1,
  input  logic [W-1:0]             c2,
  input  logic [W-1:0]             voted,
  output tmr_vote_pkg::copy_mask_t diff,
  output logic                     any_diff,
  output logic                     multi_diff
);
  import tmr_vote_pkg::*;

  logic [W-1:0] copies [NUM_COPIES];
  assign copies[0] = c0;
  assign copies[1] = c1;
  assign copies[2] = c2;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_cmp
    assign diff[k] = (copies[k] != voted);
  end

  assign any_diff   = |diff;
  assign multi_diff = (diff[0] & diff[1]) | (diff[1] & diff[2]) | (diff[0] & diff[2]);
endmodule

// File: rtl/tmr_vote_top.sv
module tmr_vote_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] copy0_data,
  input  logic             copy0_valid,
  input  logic [WIDTH-1:0] copy1_data,
  input  logic             copy1_valid,
  input  logic [WIDTH-1:0] copy2_data,
  input  logic             copy2_valid,
  output logic [WIDTH-1:0] vote_data,
  output logic             vote_valid,
  output logic [2:0]       fault_mask,
  output logic             mismatch,
  output logic             uncorrectable
);
  import tmr_vote_pkg::*;

  localparam int WORD = WIDTH + 1;

  logic [WORD-1:0] w0, w1, w2, wv;
  copy_mask_t      diff;
  logic            any_diff, multi_diff;

  assign w0 = {copy0_valid, copy0_data};
  assign w1 = {copy1_valid, copy1_data};
  assign w2 = {copy2_valid, copy2_data};

  tmr_voter_bank #(.W(WORD)) u_bank (
    .in0  (w0),
    .in1  (w1),
    .in2  (w2),
    .voted(wv)
  );

  tmr_copy_compare #(.W(WORD)) u_cmp (
    .c0        (w0),
    .c1        (w1),
    .c2        (w2),
    .voted     (wv),
    .diff      (diff),
    .any_diff  (any_diff),
    .multi_diff(multi_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vote_data     <= '0;
      vote_valid    <= 1'b0;
      fault_mask    <= '0;
      mismatch      <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      vote_data     <= wv[WIDTH-1:0];
      vote_valid    <= wv[WIDTH];
      fault_mask    <= diff;
      mismatch      <= any_diff;
      uncorrectable <= multi_diff;
    end
  end
endmodule

// File: rtl/tmr_vote_chk.sv
module tmr_vote_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] copy0_data,
  input logic             copy0_valid,
  input logic [WIDTH-1:0] copy1_data,
  input logic             copy1_valid,
  input logic [WIDTH-1:0] copy2_data,
  input logic             copy2_valid,
  input logic [WIDTH-1:0] vote_data,
  input logic             vote_valid,
  input logic [2:0]       fault_mask,
  input logic             mismatch,
  input logic             uncorrectable
);
  logic [WIDTH:0] a, b, c;
  assign a = {copy0_valid, copy0_data};
  assign b = {copy1_valid, copy1_data};
  assign c = {copy2_valid, copy2_data};

  // R1
  data_vote_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> vote_data == (($past(copy0_data) & $past(copy1_data)) |
                          ($past(copy1_data) & $past(copy2_data)) |
                          ($past(copy0_data) & $past(copy2_data))));

  // R2
  single_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && a == b && c != a) |=> ({vote_valid, vote_data} == $past(a)) && fault_mask == 3'b100);

  // R3
  valid_vote_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && copy0_valid && copy1_valid) |=> vote_valid);

  // R5
  mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(a == b && b == c)) |=> mismatch);

  // R8
  agree_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && a == b && b == c) |=> !mismatch && fault_mask == 3'b000 && !uncorrectable);

  // R6
  uncorr_count_chk: assert property (@(posedge clk) disable iff (rst)
    uncorrectable |-> $countones(fault_mask) >= 2);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> vote_data == '0 && !vote_valid && fault_mask == 3'b000 && !mismatch && !uncorrectable);
endmodule

bind tmr_vote_top tmr_vote_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tmr_vote_top_test.sv
module tmr_vote_top_test;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] d0 = '0, d1 = '0, d2 = '0;
  logic             v0 = 1'b0, v1 = 1'b0, v2 = 1'b0;
  logic [WIDTH-1:0] vote_data;
  logic             vote_valid;
  logic [2:0]       fault_mask;
  logic             mismatch, uncorrectable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected values for the outputs after the next edge
  logic [WIDTH-1:0] exp_data;
  logic             exp_valid;
  logic [2:0]       exp_mask;
  int               n_bad;
  bit               exp_rst;

  always #10 clk = ~clk;

  tmr_vote_top #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst),
    .copy0_data(d0), .copy0_valid(v0),
    .copy1_data(d1), .copy1_valid(v1),
    .copy2_data(d2), .copy2_valid(v2),
    .vote_data(vote_data), .vote_valid(vote_valid),
    .fault_mask(fault_mask), .mismatch(mismatch), .uncorrectable(uncorrectable)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model: majority per bit by counting ones
  task automatic model();
    logic [WIDTH:0] w [3];
    logic [WIDTH:0] m;
    w[0] = {v0, d0}; w[1] = {v1, d1}; w[2] = {v2, d2};
    for (int i = 0; i <= WIDTH; i++) begin
      int ones = 0;
      for (int k = 0; k < 3; k++) ones += w[k][i];
      m[i] = (ones >= 2);
    end
    exp_rst   = rst;
    exp_data  = m[WIDTH-1:0];
    exp_valid = m[WIDTH];
    n_bad = 0;
    for (int k = 0; k < 3; k++) begin
      exp_mask[k] = (w[k] != m);
      if (w[k] != m) n_bad++;
    end
  endtask

  task automatic verify();
    if (exp_rst) begin
      check("R7 data", vote_data, 0);
      check("R7 valid", vote_valid, 0);
      check("R7 mask", fault_mask, 0);
      check("R7 mismatch", mismatch, 0);
      check("R7 uncorrectable", uncorrectable, 0);
    end else begin
      check("R1 data", vote_data, exp_data);
      check("R3 valid", vote_valid, exp_valid);
      check("R4 mask", fault_mask, exp_mask);
      check("R5 mismatch", mismatch, n_bad > 0);
      check("R6 uncorrectable", uncorrectable, n_bad >= 2);
      if (n_bad == 1) check("R2 masked", {vote_valid, vote_data}, {exp_valid, exp_data});
      if (n_bad == 0) check("R8 clean", {fault_mask, mismatch, uncorrectable}, 0);
    end
  endtask

  // apply a stimulus at a falling edge, check it at the next one
  task automatic step(input logic r,
                      input logic a_v, input logic [WIDTH-1:0] a_d,
                      input logic b_v, input logic [WIDTH-1:0] b_d,
                      input logic c_v, input logic [WIDTH-1:0] c_d);
    rst = r; v0 = a_v; d0 = a_d; v1 = b_v; d1 = b_d; v2 = c_v; d2 = c_d;
    model();
    @(negedge clk);
    verify();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] base, f1, f2, f3;
    logic bv;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1, 16'hFFFF, 1, 16'hFFFF, 1, 16'hFFFF);
    // R8: all agree
    for (int i = 0; i < 40; i++) begin
      base = 16'($urandom); bv = 1'($urandom);
      step(0, bv, base, bv, base, bv, base);
    end
    // R2: one copy faulty, each position
    for (int i = 0; i < 90; i++) begin
      base = 16'($urandom); bv = 1'($urandom);
      f1 = 16'($urandom) | 16'h1;
      case (i % 3)
        0: step(0, bv, base ^ f1, bv, base, bv, base);
        1: step(0, bv, base, bv, base ^ f1, bv, base);
        default: step(0, bv, base, bv, base, bv, base ^ f1);
      endcase
    end
    // R3/R5: valid-only disagreement
    for (int i = 0; i < 12; i++) begin
      base = 16'($urandom);
      step(0, i[0], base, ~i[0], base, i[1] ? i[0] : ~i[0], base);
    end
    // R6: two or three copies wrong in disjoint bits
    for (int i = 0; i < 60; i++) begin
      base = 16'($urandom); bv = 1'($urandom);
      f1 = 16'h1 << (i % 5);
      f2 = 16'h100 << (i % 5);
      f3 = (i % 2 == 0) ? 16'h0 : (16'h20 << (i % 3));
      step(0, bv, base ^ f1, bv, base ^ f2, bv, base ^ f3);
    end
    // mid-run reset with disagreeing inputs
    step(1, 1, 16'hAAAA, 0, 16'h5555, 1, 16'h0F0F);
    step(1, 1, 16'h1234, 1, 16'h1234, 1, 16'h1234);
    // fully random
    for (int i = 0; i < 200; i++)
      step(0, 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
           1'($urandom), 16'($urandom));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule